// File: doc/BRIEF.md
# Hashed Inverted Page Table Search Engine

This block resolves a virtual page number (VPN) for a given process identifier (PID) into a physical page number (PPN). It does this by searching an inverted page table that lives in ordinary memory. The table is organised as slots. Each slot holds a fixed group of entries, and each entry pairs a VPN tag and a PID with a PPN.

For a request, the engine folds the VPN into a slot number. It adds the slot's word offset to the table base supplied with the request, and then fetches the slot's entries one word at a time over a single-outstanding memory read port. The response latency on that port is arbitrary. If no entry in that first slot matches, the engine computes a second slot number with an alternate hash and scans that slot the same way. Only when both slots fail does it return a miss, which software then resolves.

The result is a one-cycle pulse. It carries:
- the hit flag,
- the PPN,
- the slot that was being scanned,
- the entry position within that slot,
- whether that slot was the alternate one.

Top module: `hpt_walker`

## Requirements
- R1: After a synchronous active-high reset, `req_ready` is 1, and both `mem_req` and `res_valid` are 0.
- R2: The primary slot number is the XOR of the upper half and the lower half of the VPN, keeping the low `SLOT_BITS` bits. The first read goes to word address `base + slot*WAYS + 0`, wrapping at `ADDR_W` bits.
- R3: Entries are read one at a time, at positions 0, 1, 2 and so on. `mem_req` is a one-cycle pulse. The next read is issued only after the response to the previous read has arrived, so at most one read is outstanding.
- R4: An entry word is laid out MSB to LSB as {valid (1 bit), PID, VPN, PPN}, with the PPN in the least significant bits. An entry is a hit only when valid is 1 and both its VPN and its PID equal the request's.
- R5: The search stops at the first matching entry. After a hit at position k of the primary slot, exactly k+1 reads have been made.
- R6: The alternate slot is the bitwise complement of the primary slot under the same mask. It is scanned only after all WAYS entries of the primary slot fail, and a hit found there reports `res_alt` = 1. A match in the primary slot wins over any match in the alternate slot.
- R7: When both slots fail, the engine makes exactly 2*WAYS reads and then reports `res_hit` = 0, `res_alt` = 1 and `res_idx` = WAYS-1.
- R8: An entry whose valid bit is 0 never produces a hit, even if its VPN and PID equal the request's.
- R9: The result is a one-cycle `res_valid` pulse carrying the PPN, slot, index and alternate flag. `req_ready` is 0 while a search is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_ready | output | 1 | Engine idle; the request is taken on this cycle |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_pid | input | PID_W | Requesting process identifier |
| req_base | input | ADDR_W | Table base word address |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Read word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | ENT_W | Entry word read from memory |
| res_valid | output | 1 | Result pulse |
| res_hit | output | 1 | Translation found |
| res_ppn | output | PPN_W | Physical page number (0 on a miss) |
| res_slot | output | SLOT_BITS | Slot being scanned when the search ended |
| res_idx | output | IDX_W | Entry position within that slot |
| res_alt | output | 1 | The reported slot is the alternate one |

## Verification
The hardest case to reach from the ports is a hit deep inside the alternate slot. Getting there needs every primary entry to fail, including decoy entries that almost match. The bench builds that case directly. It fills the primary slot with entries that share the VPN but carry a different PID, or carry a different VPN. It then places the true entry at each of the eight positions of the alternate slot in turn. Every read address is logged and compared with the expected slot/index walk. The memory model varies its response latency from one read to the next, so the single-outstanding handshake is exercised across different delays.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } walk_state_t;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int VPN_W     = 16,
  parameter int SLOT_BITS = 4
) (
  input  logic [VPN_W-1:0]     vpn,
  output logic [SLOT_BITS-1:0] prim_slot,
  output logic [SLOT_BITS-1:0] alt_slot
);
  localparam int HALF = VPN_W / 2;

  logic [HALF-1:0] folded;

  always_comb begin
    folded    = vpn[VPN_W-1 -: HALF] ^ vpn[HALF-1:0];
    prim_slot = folded[SLOT_BITS-1:0];
    alt_slot  = ~folded[SLOT_BITS-1:0];
  end

  initial begin
    if (VPN_W % 2 != 0) $error("VPN_W must be even");
    if (SLOT_BITS > HALF) $error("SLOT_BITS exceeds folded width");
  end
endmodule

// File: rtl/hpt_match.sv
module hpt_match #(
  parameter int VPN_W = 16,
  parameter int PID_W = 4,
  parameter int PPN_W = 12,
  localparam int ENT_W = 1 + PID_W + VPN_W + PPN_W
) (
  input  logic [ENT_W-1:0] word,
  input  logic [VPN_W-1:0] vpn,
  input  logic [PID_W-1:0] pid,
  output logic             hit,
  output logic [PPN_W-1:0] ppn
);
  logic             e_valid;
  logic [PID_W-1:0] e_pid;
  logic [VPN_W-1:0] e_vpn;

  always_comb begin
    e_valid = word[ENT_W-1];
    e_pid   = word[PPN_W+VPN_W +: PID_W];
    e_vpn   = word[PPN_W +: VPN_W];
    ppn     = word[PPN_W-1:0];
    // invalid entries are skipped: no tag comparison contributes
    hit     = e_valid && (e_vpn == vpn) && (e_pid == pid);
  end
endmodule

// File: rtl/hpt_ctrl.sv
module hpt_ctrl
  import hpt_pkg::*;
#(
  parameter int VPN_W     = 16,
  parameter int PID_W     = 4,
  parameter int PPN_W     = 12,
  parameter int ADDR_W    = 10,
  parameter int SLOT_BITS = 4,
  parameter int WAYS      = 8,
  localparam int IDX_W    = $clog2(WAYS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VPN_W-1:0]     req_vpn,
  input  logic [PID_W-1:0]     req_pid,
  input  logic [ADDR_W-1:0]    req_base,
  input  logic [SLOT_BITS-1:0] hash_prim,
  input  logic [SLOT_BITS-1:0] hash_alt,
  output logic [VPN_W-1:0]     cur_vpn,
  output logic [PID_W-1:0]     cur_pid,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic                 mem_rsp_valid,
  input  logic                 ent_hit,
  input  logic [PPN_W-1:0]     ent_ppn,
  output logic                 res_valid,
  output logic                 res_hit,
  output logic [PPN_W-1:0]     res_ppn,
  output logic [SLOT_BITS-1:0] res_slot,
  output logic [IDX_W-1:0]     res_idx,
  output logic                 res_alt
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WAYS - 1);

  walk_state_t          state;
  logic [ADDR_W-1:0]    base_q;
  logic [SLOT_BITS-1:0] slot_q;
  logic [SLOT_BITS-1:0] alt_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 second_q;
  logic [IDX_W-1:0]     idx_nxt;

  assign req_ready = (state == ST_IDLE);
  assign idx_nxt   = idx_q + 1'b1;

  function automatic logic [ADDR_W-1:0] word_addr(
    input logic [ADDR_W-1:0] b, input logic [SLOT_BITS-1:0] s, input logic [IDX_W-1:0] i);
    return b + ADDR_W'({s, i});
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_ppn   <= '0;
      res_slot  <= '0;
      res_idx   <= '0;
      res_alt   <= 1'b0;
      base_q    <= '0;
      slot_q    <= '0;
      alt_q     <= '0;
      idx_q     <= '0;
      second_q  <= 1'b0;
      cur_vpn   <= '0;
      cur_pid   <= '0;
    end else begin
      mem_req   <= 1'b0;
      res_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_vpn  <= req_vpn;
            cur_pid  <= req_pid;
            base_q   <= req_base;
            slot_q   <= hash_prim;
            alt_q    <= hash_alt;
            idx_q    <= '0;
            second_q <= 1'b0;
            mem_req  <= 1'b1;
            mem_addr <= word_addr(req_base, hash_prim, '0);
            state    <= ST_WAIT;
          end
        end
        default: begin
          if (mem_rsp_valid) begin
            if (ent_hit) begin
              res_valid <= 1'b1;
              res_hit   <= 1'b1;
              res_ppn   <= ent_ppn;
              res_slot  <= slot_q;
              res_idx   <= idx_q;
              res_alt   <= second_q;
              state     <= ST_IDLE;
            end else if (idx_q == LAST_IDX) begin
              if (!second_q) begin
                second_q <= 1'b1;
                slot_q   <= alt_q;
                idx_q    <= '0;
                mem_req  <= 1'b1;
                mem_addr <= word_addr(base_q, alt_q, '0);
              end else begin
                res_valid <= 1'b1;
                res_hit   <= 1'b0;
                res_ppn   <= '0;
                res_slot  <= slot_q;
                res_idx   <= idx_q;
                res_alt   <= 1'b1;
                state     <= ST_IDLE;
              end
            end else begin
              idx_q    <= idx_nxt;
              mem_req  <= 1'b1;
              mem_addr <= word_addr(base_q, slot_q, idx_nxt);
            end
          end
        end
      endcase
    end
  end

  // R3: a read request lasts exactly one cycle
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R3: responses only arrive while a read is outstanding
  p_rsp_when_busy_r3: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |-> (state == ST_WAIT) && !mem_req);

  // R9: the result is a single-cycle pulse
  p_res_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  initial begin
    if ((1 << IDX_W) != WAYS) $error("WAYS must be a power of two");
    if (SLOT_BITS + IDX_W > ADDR_W) $error("table does not fit address");
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int VPN_W     = 16,
  parameter int PID_W     = 4,
  parameter int PPN_W     = 12,
  parameter int ADDR_W    = 10,
  parameter int SLOT_BITS = 4,
  parameter int WAYS      = 8,
  localparam int IDX_W    = $clog2(WAYS),
  localparam int ENT_W    = 1 + PID_W + VPN_W + PPN_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VPN_W-1:0]     req_vpn,
  input  logic [PID_W-1:0]     req_pid,
  input  logic [ADDR_W-1:0]    req_base,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic                 mem_rsp_valid,
  input  logic [ENT_W-1:0]     mem_rsp_data,
  output logic                 res_valid,
  output logic                 res_hit,
  output logic [PPN_W-1:0]     res_ppn,
  output logic [SLOT_BITS-1:0] res_slot,
  output logic [IDX_W-1:0]     res_idx,
  output logic                 res_alt
);
  logic [SLOT_BITS-1:0] hash_prim, hash_alt;
  logic [VPN_W-1:0]     cur_vpn;
  logic [PID_W-1:0]     cur_pid;
  logic                 ent_hit;
  logic [PPN_W-1:0]     ent_ppn;

  hpt_hash #(.VPN_W(VPN_W), .SLOT_BITS(SLOT_BITS)) u_hash (
    .vpn(req_vpn), .prim_slot(hash_prim), .alt_slot(hash_alt)
  );

  hpt_match #(.VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W)) u_match (
    .word(mem_rsp_data), .vpn(cur_vpn), .pid(cur_pid),
    .hit(ent_hit), .ppn(ent_ppn)
  );

  hpt_ctrl #(
    .VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W), .ADDR_W(ADDR_W),
    .SLOT_BITS(SLOT_BITS), .WAYS(WAYS)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_pid(req_pid), .req_base(req_base),
    .hash_prim(hash_prim), .hash_alt(hash_alt),
    .cur_vpn(cur_vpn), .cur_pid(cur_pid),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .ent_hit(ent_hit), .ent_ppn(ent_ppn),
    .res_valid(res_valid), .res_hit(res_hit), .res_ppn(res_ppn),
    .res_slot(res_slot), .res_idx(res_idx), .res_alt(res_alt)
  );

  // R7: a miss is only reported at the last entry of the alternate slot
  p_miss_end_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_alt && res_idx == IDX_W'(WAYS - 1)));

  // R3: an accepted request starts a memory read on the next cycle
  p_accept_issue_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> mem_req);

  // R9: no read is pending while the engine reports itself idle
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
endmodule

// File: tb/hpt_walker_tb.sv
`timescale 1ns/1ps
module hpt_walker_tb;
  localparam int VPN_W = 16, PID_W = 4, PPN_W = 12, ADDR_W = 10;
  localparam int SLOT_BITS = 4, WAYS = 8, IDX_W = 3;
  localparam int ENT_W = 1 + PID_W + VPN_W + PPN_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VPN_W-1:0] req_vpn = '0;
  logic [PID_W-1:0] req_pid = '0;
  logic [ADDR_W-1:0] req_base = '0;
  logic mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_rsp_valid;
  logic [ENT_W-1:0] mem_rsp_data;
  logic res_valid, res_hit, res_alt;
  logic [PPN_W-1:0] res_ppn;
  logic [SLOT_BITS-1:0] res_slot;
  logic [IDX_W-1:0] res_idx;

  always #2 clk = ~clk;

  hpt_walker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_pid(req_pid), .req_base(req_base),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_hit(res_hit), .res_ppn(res_ppn),
    .res_slot(res_slot), .res_idx(res_idx), .res_alt(res_alt)
  );

  // behavioural memory with latency varying 1..4 cycles
  logic [ENT_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addr_log [32];
  int rd_count = 0;
  logic busy = 1'b0;
  int cnt = 0;
  logic [ADDR_W-1:0] pend_addr = '0;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (rst) begin
      busy <= 1'b0;
      mem_rsp_data <= '0;
    end else if (mem_req) begin
      busy <= 1'b1;
      cnt <= rd_count % 4;
      pend_addr <= mem_addr;
      addr_log[rd_count % 32] <= mem_addr;
      rd_count <= rd_count + 1;
    end else if (busy) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data <= mem[pend_addr];
        busy <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [SLOT_BITS-1:0] hprim(input logic [VPN_W-1:0] v);
    logic [7:0] f;
    f = v[15:8] ^ v[7:0];
    return f[SLOT_BITS-1:0];
  endfunction

  function automatic logic [SLOT_BITS-1:0] halt(input logic [VPN_W-1:0] v);
    return ~hprim(v);
  endfunction

  function automatic logic [ENT_W-1:0] mk(input bit vld, input logic [PID_W-1:0] p,
                                          input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] pp);
    return {vld, p, v, pp};
  endfunction

  function automatic logic [ADDR_W-1:0] ea(input logic [ADDR_W-1:0] b,
                                           input logic [SLOT_BITS-1:0] s, input int i);
    return b + ADDR_W'(s * WAYS + i);
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  // observed results of the last lookup
  bit o_hit, o_alt, o_busy_seen;
  logic [PPN_W-1:0] o_ppn;
  logic [SLOT_BITS-1:0] o_slot;
  logic [IDX_W-1:0] o_idx;
  int o_reads, o_start;

  task automatic lookup(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                        input logic [ADDR_W-1:0] b);
    int guard;
    @(negedge clk);
    o_start = rd_count;
    req_vpn = v; req_pid = p; req_base = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    o_busy_seen = !req_ready;
    guard = 0;
    while (!res_valid && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 2000) chk(0, "R9 watchdog on result", guard, 0);
    o_hit = res_hit; o_alt = res_alt; o_ppn = res_ppn;
    o_slot = res_slot; o_idx = res_idx;
    o_reads = rd_count - o_start;
    @(negedge clk);
    chk(!res_valid, "R9 result pulse width", res_valid, 0);
  endtask

  // checks the logged address walk against the expected slot/index order
  task automatic chk_walk(input logic [VPN_W-1:0] v, input logic [ADDR_W-1:0] b, input string tag);
    int bad = 0;
    logic [ADDR_W-1:0] first = '0;
    for (int i = 0; i < o_reads && i < 2 * WAYS; i++) begin
      logic [ADDR_W-1:0] e;
      e = (i < WAYS) ? ea(b, hprim(v), i) : ea(b, halt(v), i - WAYS);
      if (i == 0) first = addr_log[(o_start + i) % 32];
      if (addr_log[(o_start + i) % 32] != e) bad++;
    end
    chk(bad == 0, tag, first, ea(b, hprim(v), 0));
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready in reset", req_ready, 1);
    chk(mem_req == 1'b0, "R1 mem_req in reset", mem_req, 0);
    chk(res_valid == 1'b0, "R1 res_valid in reset", res_valid, 0);
    rst = 1'b0;
    @(negedge clk);

    // R5/R6 sweep: target at every position of both slots, with decoys
    for (int sec = 0; sec < 2; sec++) begin
      for (int w = 0; w < WAYS; w++) begin
        logic [VPN_W-1:0] v;
        logic [PID_W-1:0] p;
        logic [ADDR_W-1:0] b;
        logic [SLOT_BITS-1:0] ts;
        logic [PPN_W-1:0] pp;
        v = VPN_W'(16'h1234 + w * 37 + sec * 1111);
        p = PID_W'(w + 3);
        b = (w % 2 == 0) ? 10'h000 : 10'h180;
        pp = PPN_W'(12'h0A0 + w + sec * 16);
        clear_mem();
        for (int k = 0; k < WAYS; k++) begin
          mem[ea(b, hprim(v), k)] = (k % 2 == 0) ? mk(1, p + 1'b1, v, 12'hFFF)
                                                 : mk(1, p, v ^ 16'h0100, 12'hFFE);
        end
        ts = sec ? halt(v) : hprim(v);
        mem[ea(b, ts, w)] = mk(1, p, v, pp);
        lookup(v, p, b);
        chk(o_hit == 1'b1, "R6 sweep hit", o_hit, 1);
        chk(o_ppn == pp, "R5 sweep ppn", o_ppn, pp);
        chk(o_idx == IDX_W'(w), "R5 sweep index", o_idx, w);
        chk(o_slot == ts, "R2 sweep slot", o_slot, ts);
        chk(o_alt == bit'(sec), "R6 sweep alt flag", o_alt, sec);
        chk(o_reads == sec * WAYS + w + 1, "R5 sweep read count", o_reads, sec * WAYS + w + 1);
        chk_walk(v, b, "R3 sweep address walk");
        chk(o_busy_seen, "R9 req_ready low while busy", !o_busy_seen, 0);
      end
    end

    // R7 plain miss
    clear_mem();
    lookup(16'hBEEF, 4'd2, 10'h040);
    chk(o_hit == 1'b0, "R7 miss hit flag", o_hit, 0);
    chk(o_reads == 2 * WAYS, "R7 miss read count", o_reads, 2 * WAYS);
    chk(o_alt == 1'b1 && o_idx == 3'd7, "R7 miss alt/idx", {o_alt, o_idx}, {1'b1, 3'd7});
    chk(o_slot == halt(16'hBEEF), "R7 miss slot", o_slot, halt(16'hBEEF));

    // R4 PID mismatch in both slots gives a miss
    clear_mem();
    mem[ea(10'h040, hprim(16'h5A5A), 3)] = mk(1, 4'd9, 16'h5A5A, 12'h111);
    mem[ea(10'h040, halt(16'h5A5A), 1)] = mk(1, 4'd8, 16'h5A5A, 12'h222);
    lookup(16'h5A5A, 4'd7, 10'h040);
    chk(o_hit == 1'b0, "R4 pid mismatch misses", o_hit, 0);

    // R8 invalid matching entry skipped, later valid one found
    clear_mem();
    mem[ea(10'h200, hprim(16'h0F0F), 1)] = mk(0, 4'd5, 16'h0F0F, 12'h333);
    mem[ea(10'h200, hprim(16'h0F0F), 4)] = mk(1, 4'd5, 16'h0F0F, 12'h444);
    lookup(16'h0F0F, 4'd5, 10'h200);
    chk(o_hit && o_idx == 3'd4 && o_ppn == 12'h444, "R8 invalid skipped", o_idx, 4);

    // R8 only invalid copies: miss
    clear_mem();
    mem[ea(10'h200, hprim(16'h0F0F), 0)] = mk(0, 4'd5, 16'h0F0F, 12'h333);
    mem[ea(10'h200, halt(16'h0F0F), 0)] = mk(0, 4'd5, 16'h0F0F, 12'h334);
    lookup(16'h0F0F, 4'd5, 10'h200);
    chk(o_hit == 1'b0, "R8 invalid never hits", o_hit, 0);

    // R5 first match wins
    clear_mem();
    mem[ea(10'h010, hprim(16'hC3C3), 2)] = mk(1, 4'd1, 16'hC3C3, 12'h555);
    mem[ea(10'h010, hprim(16'hC3C3), 5)] = mk(1, 4'd1, 16'hC3C3, 12'h666);
    lookup(16'hC3C3, 4'd1, 10'h010);
    chk(o_idx == 3'd2 && o_ppn == 12'h555 && o_reads == 3, "R5 first match", o_ppn, 12'h555);

    // R6 primary wins over alternate
    clear_mem();
    mem[ea(10'h010, hprim(16'h7711), 6)] = mk(1, 4'd4, 16'h7711, 12'h777);
    mem[ea(10'h010, halt(16'h7711), 0)] = mk(1, 4'd4, 16'h7711, 12'h888);
    lookup(16'h7711, 4'd4, 10'h010);
    chk(o_alt == 1'b0 && o_ppn == 12'h777, "R6 primary priority", o_ppn, 12'h777);

    // R2 hash sweep over many VPNs (empty table, full walk checked)
    clear_mem();
    for (int n = 0; n < 48; n++) begin
      logic [VPN_W-1:0] v;
      logic [ADDR_W-1:0] b;
      v = VPN_W'(n * 16'h0531 + n * n);
      b = ADDR_W'(n * 7);
      lookup(v, 4'd0, b);
      chk_walk(v, b, "R2 hash address walk");
      chk(o_reads == 2 * WAYS, "R7 sweep read count", o_reads, 2 * WAYS);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule